// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Cross-Conduction Guard

This block turns the three logic controls of one H-bridge (an enable and one level request per leg) into the four gate-enable signals of its power switches: an upper and a lower switch on each of the two legs. A request of 1 asks for the leg output to be tied to the supply through the upper switch. A request of 0 asks for it to be tied to ground through the lower switch. With the enable low, every switch is off and both leg outputs float.

Each leg keeps its own guard counter. Whenever a switch is about to turn on, the leg first holds both of its gates low for a programmable number of clock cycles, `DEAD_CYC`. The default is 200 cycles, which is 1 µs at a 200 MHz clock. If the request reverses while the guard interval is running, the interval starts again. Turning a switch off never waits. All three controls pass through a two-stage synchronizer before use. A chip with two bridges places two independent instances.

Top module: `hb_bridge_gate`

## Requirements
- R1: A synchronous reset turns all four gates off and sets both `leg_hiz` bits to 1 on the edge that samples it.
- R2: After `en` goes low, all four gates are off from the third clock edge onward (two synchronizer stages plus one register). They stay off whatever `in1` and `in2` do while `en` stays low.
- R3: With `en` high and enough time given, request 1 on a leg leaves only its upper gate on, and request 0 leaves only its lower gate on. `in1` drives leg 0 (bit 0 of each output) and `in2` drives leg 1 (bit 1).
- R4: Equal requests on both legs are valid braking states. Both 0 gives `gate_lo`=11, and both 1 gives `gate_hi`=11.
- R5: The upper and lower gates of the same leg are never on in the same cycle.
- R6: A gate turns on exactly at the `DEAD_CYC`-th clock edge after the leg's most recent wait start. Both gates of that leg are low in between. A wait starts on any edge where the synchronized enable is low, or where the synchronized request differs from the switch that is on, or differs from the request being waited for.
- R7: A request that reverses before the guard interval ends restarts the interval for the new value. No switch turns on early.
- R8: A request change turns the conducting switch of that leg off at the third clock edge after the change, with no guard delay.
- R9: The two legs are independent. A change on one leg's request leaves the other leg's gates untouched.
- R10: Each `leg_hiz` bit is 1 exactly when both gates of that leg are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Bridge enable. Low forces every switch off |
| in1 | input | 1 | Level request for leg 0 (1 = supply, 0 = ground) |
| in2 | input | 1 | Level request for leg 1 |
| gate_hi | output | 2 | Upper switch gate enables, bit g = leg g |
| gate_lo | output | 2 | Lower switch gate enables, bit g = leg g |
| leg_hiz | output | 2 | Leg g output floating (both its switches off) |

## Verification
Two events can land on the same edge. The first is the expiry of a leg's guard count, which would turn a gate on. The second is a disable or a request reversal, which must win and restart or cancel the wait. Random stimulus with hold times both shorter and longer than `DEAD_CYC` makes these collisions frequent, and a directed reversal places one exactly inside the interval. A cycle model in the bench, built from R2, R6 and R8, predicts every gate on every cycle, so a turn-on that is one cycle early or late, or that survives a same-edge cancel, shows up as a mismatch.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int NUM_LEGS = 2;

    typedef enum logic [1:0] {
        LEG_WAIT = 2'd0,
        LEG_LOW  = 2'd1,
        LEG_HIGH = 2'd2
    } leg_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_gate_t;

    function automatic leg_gate_t gate_of(input leg_state_e s);
        leg_gate_t g;
        g.hi = (s == LEG_HIGH);
        g.lo = (s == LEG_LOW);
        return g;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 200
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_s,
    input  logic      req_s,
    output leg_gate_t gate
);
    localparam int CW = $clog2(DEAD_CYC + 1);

    leg_state_e    st;
    logic [CW-1:0] cnt;
    logic          want;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LEG_WAIT;
            cnt  <= '0;
            want <= 1'b0;
        end else if (!en_s) begin
            st   <= LEG_WAIT;
            cnt  <= '0;
            want <= req_s;
        end else begin
            case (st)
                LEG_HIGH: if (!req_s) begin
                    st   <= LEG_WAIT;
                    cnt  <= '0;
                    want <= 1'b0;
                end
                LEG_LOW: if (req_s) begin
                    st   <= LEG_WAIT;
                    cnt  <= '0;
                    want <= 1'b1;
                end
                default: begin
                    if (req_s != want) begin
                        want <= req_s;
                        cnt  <= '0;
                    end else if (cnt == CW'(DEAD_CYC - 1)) begin
                        st <= want ? LEG_HIGH : LEG_LOW;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign gate = gate_of(st);

    // Checker: consecutive cycles with both gates of this leg low
    logic [CW-1:0] off_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            off_run <= '0;
        end else if (!gate.hi && !gate.lo) begin
            if (off_run != CW'(DEAD_CYC)) off_run <= off_run + 1'b1;
        end else begin
            off_run <= '0;
        end
    end

    a_r5_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
        !(gate.hi && gate.lo));

    a_r6_guard_before_hi: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.hi) |-> off_run >= CW'(DEAD_CYC));

    a_r6_guard_before_lo: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.lo) |-> off_run >= CW'(DEAD_CYC));

    a_r2_disable_kills: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> (!gate.hi && !gate.lo));

    a_r8_hi_drops_at_once: assert property (@(posedge clk) disable iff (rst)
        (gate.hi && !req_s) |=> !gate.hi);

    a_r8_lo_drops_at_once: assert property (@(posedge clk) disable iff (rst)
        (gate.lo && req_s) |=> !gate.lo);
endmodule

// File: rtl/hb_bridge_gate.sv
module hb_bridge_gate
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                in1,
    input  logic                in2,
    output logic [NUM_LEGS-1:0] gate_hi,
    output logic [NUM_LEGS-1:0] gate_lo,
    output logic [NUM_LEGS-1:0] leg_hiz
);
    localparam int SW = NUM_LEGS + 1;

    logic [SW-1:0] raw_ctl;
    logic [SW-1:0] sync_ctl;

    assign raw_ctl = {in2, in1, en};

    hb_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_ctl),
        .q   (sync_ctl)
    );

    generate
        for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
            leg_gate_t lg;
            hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
                .clk   (clk),
                .rst   (rst),
                .en_s  (sync_ctl[0]),
                .req_s (sync_ctl[g+1]),
                .gate  (lg)
            );
            assign gate_hi[g] = lg.hi;
            assign gate_lo[g] = lg.lo;
            assign leg_hiz[g] = ~(lg.hi | lg.lo);
        end
    endgenerate

    a_r1_reset_all_off: assert property (@(posedge clk)
        rst |=> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: tb/sim_hb_bridge_gate.sv
`timescale 1ns/1ps
module sim_hb_bridge_gate;
    localparam int DEAD = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, in1 = 1'b0, in2 = 1'b0;
    logic [1:0] gate_hi, gate_lo, leg_hiz;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hb_bridge_gate #(.DEAD_CYC(DEAD)) u0 (
        .clk(clk), .rst(rst), .en(en), .in1(in1), .in2(in2),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .leg_hiz(leg_hiz)
    );

    // Reference model: two-cycle input delay (R2/R8), guard rule (R6)
    logic [2:0] m_p1, m_p2;
    int m_on  [2];   // 0 off, 1 lower on, 2 upper on
    bit m_req [2];
    int m_cnt [2];

    always @(posedge clk) begin
        if (rst) begin
            m_p1 = '0; m_p2 = '0;
            for (int g = 0; g < 2; g++) begin
                m_on[g] = 0; m_req[g] = 1'b0; m_cnt[g] = 0;
            end
        end else begin
            for (int g = 0; g < 2; g++) begin
                bit e, v;
                e = m_p2[0];
                v = m_p2[g+1];
                if (!e) begin
                    m_on[g] = 0; m_cnt[g] = 0; m_req[g] = v;
                end else if (m_on[g] != 0) begin
                    if (v != (m_on[g] == 2)) begin
                        m_on[g] = 0; m_cnt[g] = 0; m_req[g] = v;
                    end
                end else if (v != m_req[g]) begin
                    m_req[g] = v; m_cnt[g] = 0;
                end else begin
                    m_cnt[g]++;
                    if (m_cnt[g] >= DEAD) m_on[g] = m_req[g] ? 2 : 1;
                end
            end
            m_p2 = m_p1;
            m_p1 = {in2, in1, en};
        end
    end

    function automatic logic [1:0] exp_hi();
        return {m_on[1] == 2, m_on[0] == 2};
    endfunction
    function automatic logic [1:0] exp_lo();
        return {m_on[1] == 1, m_on[0] == 1};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic cmp_model(input string tag);
        chk(tag, "gate_hi", gate_hi, exp_hi());
        chk(tag, "gate_lo", gate_lo, exp_lo());
        chk("R10", "leg_hiz", leg_hiz, ~(exp_hi() | exp_lo()));
        chk("R5", "hi&lo", gate_hi & gate_lo, 2'b00);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        cmp_model(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        in1 = 1'b1; in2 = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "gate_hi", gate_hi, 2'b00);
        chk("R1", "gate_lo", gate_lo, 2'b00);
        chk("R1", "leg_hiz", leg_hiz, 2'b11);
        rst = 1'b0;
        repeat (3) step("R2");

        // R6: enable with stable requests, turn-on exactly at edge 2+DEAD
        en = 1'b1;
        repeat (2 + DEAD - 1) step("R6");
        chk("R6", "gate_hi early", gate_hi, 2'b00);
        step("R6");
        chk("R6", "gate_hi on time", gate_hi, 2'b11);
        chk("R4", "brake high", gate_lo, 2'b00);

        // R3: leg0 high, leg1 low
        in2 = 1'b0;
        repeat (3 + DEAD + 2) step("R3");
        chk("R3", "gate_hi", gate_hi, 2'b01);
        chk("R3", "gate_lo", gate_lo, 2'b10);

        // R8: turn-off at the third edge
        in1 = 1'b0;
        repeat (2) step("R8");
        chk("R8", "hi still on", gate_hi, 2'b01);
        step("R8");
        chk("R8", "hi off", gate_hi, 2'b00);
        repeat (DEAD) step("R4");
        chk("R4", "brake low", gate_lo, 2'b11);

        // R7 / R9: reversal inside the guard interval
        in1 = 1'b1;
        repeat (3 + DEAD + 2) step("R3");
        chk("R3", "gate_hi", gate_hi, 2'b01);
        in1 = 1'b0;
        repeat (2) step("R7");
        in1 = 1'b1;
        repeat (10 - 2) step("R7");
        chk("R7", "hi held off", gate_hi, 2'b00);
        chk("R7", "lo never on", gate_lo, 2'b10);
        chk("R9", "other leg kept", gate_lo[1] ? 2'b10 : 2'b00, 2'b10);
        step("R7");
        chk("R7", "hi after restart", gate_hi, 2'b01);

        // R2: disable, then inputs ignored
        en = 1'b0;
        repeat (2) step("R2");
        chk("R2", "still on", gate_hi, 2'b01);
        step("R2");
        chk("R2", "all off hi", gate_hi, 2'b00);
        chk("R2", "all off lo", gate_lo, 2'b00);
        for (int k = 0; k < 12; k++) begin
            in1 = 1'($urandom); in2 = 1'($urandom);
            step("R2");
            chk("R2", "ignored", gate_hi | gate_lo, 2'b00);
        end

        // R1: reset while conducting
        en = 1'b1; in1 = 1'b1; in2 = 1'b0;
        repeat (3 + DEAD + 2) step("R3");
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", "mid reset hi", gate_hi, 2'b00);
        chk("R1", "mid reset lo", gate_lo, 2'b00);
        rst = 1'b0;

        // Random phase: holds shorter and longer than DEAD
        for (int it = 0; it < 600; it++) begin
            int hold;
            hold = 1 + int'($urandom % 12);
            en  = ($urandom % 8) != 0;
            in1 = 1'($urandom);
            in2 = 1'($urandom);
            for (int h = 0; h < hold; h++) step("R6/R7/R8/R9");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule